// File: doc/BRIEF.md
# Windowed PHY Register Access Sequencer

This block reaches the internal control registers of a PHY that sits behind a narrow memory-mapped window. The PHY decodes only 512 words of address space at a time. To reach one of its registers the block first writes a page selector that holds the device number and the upper internal address bits. It then reads or writes the word inside the window. On top of that two-step access, the PHY exposes an indirect command interface with three registers: control, target address and data. The block drives that interface with the required ordering and polls a busy flag in between.

A client hands over one read or write at a time on a valid/ready command port. Each command carries a 16-bit internal address, a 16-bit data value and a 5-bit device select. When the command completes, the block raises a one-cycle done pulse, with the read data and an error flag valid in that same cycle. Busy polls are spaced by a programmable number of clock ticks. A poll budget ends a command with the error flag set if the PHY stays busy.

Top module: `phywin_seq`

## Requirements
- R1: Every register access starts with a bus write to byte offset 0x800. The value written is `(dev << 7) | addr[15:9]`. This write is followed directly by the access itself at byte offset `addr[8:0] << 2`.
- R2: The block holds a bus request with a stable address, direction and write data until the cycle in which `bus_ack` is sampled high. Read data is taken from `bus_rdata` in that same cycle.
- R3: The block addresses the command interface only at internal addresses 0x80A0 (control), 0x80A1 (target address) and 0x80A2 (data).
- R4: A read polls control until bit 0 reads 0, writes the target address, writes control with value 0x0001, polls again until bit 0 reads 0, then reads the data register and returns that value.
- R5: A write polls control until bit 0 reads 0, writes the target address, writes the data register, then writes control with value 0x0003 (bit 0 start, bit 1 write). It finishes without polling again.
- R6: After a poll that reads busy, the next poll of control starts no fewer than WAIT_TICKS clock cycles later.
- R7: If MAX_POLLS polls in a row all read busy, the command ends with `err` = 1 and `rd_data` = 0, and issues no further access. Exactly MAX_POLLS busy polls are allowed before this happens, so a command whose busy flag clears on the MAX_POLLS-th poll succeeds.
- R8: `cmd_ready` is high only while the block is idle. A command is taken on `cmd_valid && cmd_ready`. A `cmd_valid` presented while busy has no effect.
- R9: `done` is a one-cycle pulse. In that cycle, `rd_data` holds the read result (0 for a write) and `err` holds the error flag. In the following cycle the block is ready again.
- R10: While reset is held and right after it, `cmd_ready` = 1 and `bus_req`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_dev | input | DEV_W | Device select |
| cmd_addr | input | IADDR_W | PHY internal register address |
| cmd_wdata | input | DATA_W | Data for a write |
| done | output | 1 | Command finished (one cycle) |
| rd_data | output | DATA_W | Read result, valid with done |
| err | output | 1 | Poll budget exhausted, valid with done |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | 12 | Byte offset into the PHY window |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Access accepted and completed |
| bus_rdata | input | DATA_W | Bus read data, valid with bus_ack |

## Verification
The assertions assume two things about the bus. First, `bus_ack` is a single-cycle response that only comes while a request is pending. Second, every request is eventually answered. The bench's PHY model keeps to this: it acks after zero to two idle cycles and drops the ack the next cycle. The stall and timeout checks assume that the busy flag clears only through polling. The model therefore reports busy for a number of polls set per command, and the driver offers a new command only after the previous done, so one command is outstanding at a time.

// File: rtl/phywin_pkg.sv
// Package: shared constants and state types for the windowed PHY sequencer.
// Assumes a 512-word window, so 9 internal address bits select the word.
package phywin_pkg;
    localparam int OFS_BITS = 9;
    localparam int BUS_AW   = OFS_BITS + 3;
    localparam logic [BUS_AW-1:0] PAGE_OFS = 12'h800;
    localparam logic [15:0] REG_CTRL = 16'h80A0;
    localparam logic [15:0] REG_TADDR = 16'h80A1;
    localparam logic [15:0] REG_TDATA = 16'h80A2;
    localparam int CTRL_GO_BIT = 0;
    localparam int CTRL_WR_BIT = 1;

    typedef enum logic [2:0] {
        STP_POLL_PRE, STP_ADDR, STP_DATA, STP_GO, STP_POLL_POST, STP_FETCH
    } step_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_ISSUE, SQ_WAIT_ACC, SQ_PACE, SQ_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        PM_IDLE, PM_PAGE, PM_WIN
    } pm_state_e;
endpackage

// File: rtl/phywin_bus_master.sv
// Module: phywin_bus_master
// Performs one PHY register access as two bus transfers. It writes the page
// selector at PAGE_OFS, then makes the windowed access. Assumes bus_ack is a
// one-cycle response that comes only while bus_req is high. acc_start is
// honoured only while acc_busy is low.
module phywin_bus_master
    import phywin_pkg::*;
#(
    parameter int DEV_W   = 5,
    parameter int IADDR_W = 16,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_start,
    input  logic               acc_we,
    input  logic [IADDR_W-1:0] acc_addr,
    input  logic [DEV_W-1:0]   acc_dev,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic               acc_busy,
    output logic               acc_done,
    output logic [DATA_W-1:0]  acc_rdata,
    output logic               bus_req,
    output logic               bus_we,
    output logic [BUS_AW-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ack,
    input  logic [DATA_W-1:0]  bus_rdata
);
    localparam int PAGE_W = IADDR_W - OFS_BITS;
    localparam int SEL_W  = DEV_W + PAGE_W;

    pm_state_e             st;
    logic                  lat_we;
    logic [OFS_BITS-1:0]   lat_off;
    logic [DATA_W-1:0]     lat_wdata;
    logic [SEL_W-1:0]      page_val;

    // Page selector: device number above the upper internal address bits.
    assign page_val = {acc_dev, acc_addr[IADDR_W-1:OFS_BITS]};
    assign acc_busy = (st != PM_IDLE);

    // Transfer sequencing: page write, then window access, then done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= PM_IDLE;
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            acc_done  <= 1'b0;
            acc_rdata <= '0;
            lat_we    <= 1'b0;
            lat_off   <= '0;
            lat_wdata <= '0;
        end else begin
            acc_done <= 1'b0;
            case (st)
                PM_IDLE: if (acc_start) begin
                    bus_req   <= 1'b1;
                    bus_we    <= 1'b1;
                    bus_addr  <= PAGE_OFS;
                    bus_wdata <= DATA_W'(page_val);
                    lat_we    <= acc_we;
                    lat_off   <= acc_addr[OFS_BITS-1:0];
                    lat_wdata <= acc_wdata;
                    st        <= PM_PAGE;
                end
                PM_PAGE: if (bus_ack) begin
                    bus_we    <= lat_we;
                    bus_addr  <= BUS_AW'({lat_off, 2'b00});
                    bus_wdata <= lat_wdata;
                    st        <= PM_WIN;
                end
                PM_WIN: if (bus_ack) begin
                    bus_req   <= 1'b0;
                    acc_rdata <= bus_rdata;
                    acc_done  <= 1'b1;
                    st        <= PM_IDLE;
                end
                default: st <= PM_IDLE;
            endcase
        end
    end

    // R1: a fresh request always opens with the page selector write.
    a_r1_page_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> (bus_we && bus_addr == PAGE_OFS));

    // R1: an acknowledged page write is followed directly by a window access.
    a_r1_window_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_addr == PAGE_OFS) |=> (bus_req && bus_addr != PAGE_OFS));

    // R2: a pending request keeps its address, direction and data.
    a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R2: the sequencer only starts an access while this unit is free.
    a_r2_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        acc_start |-> (st == PM_IDLE));
endmodule

// File: rtl/phywin_poll_pacer.sv
// Module: phywin_poll_pacer
// Spaces busy polls and counts them. wait_go starts a WAIT_TICKS delay and
// records one busy poll. wait_over pulses when the delay has run out.
// last_try flags that the current poll is the MAX_POLLS-th. Assumes wait_go
// is never raised on the last try.
module phywin_poll_pacer #(
    parameter int WAIT_TICKS = 1000,
    parameter int MAX_POLLS  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tries_clr,
    input  logic wait_go,
    output logic wait_over,
    output logic last_try
);
    localparam int WAIT_W = $clog2(WAIT_TICKS + 1);
    localparam int TRY_W  = $clog2(MAX_POLLS + 1);

    logic [WAIT_W-1:0] wait_cnt;
    logic              waiting;
    logic [TRY_W-1:0]  tries;

    assign last_try = (tries == TRY_W'(MAX_POLLS - 1));

    // Busy-poll counter and inter-poll delay countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt  <= '0;
            waiting   <= 1'b0;
            wait_over <= 1'b0;
            tries     <= '0;
        end else begin
            wait_over <= 1'b0;
            if (tries_clr)    tries <= '0;
            else if (wait_go) tries <= tries + 1'b1;
            if (wait_go) begin
                waiting  <= 1'b1;
                wait_cnt <= WAIT_W'(WAIT_TICKS - 1);
            end else if (waiting) begin
                if (wait_cnt == '0) begin
                    waiting   <= 1'b0;
                    wait_over <= 1'b1;
                end else begin
                    wait_cnt <= wait_cnt - 1'b1;
                end
            end
        end
    end

    // R6: the delay never ends in the cycle right after it starts.
    a_r6_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
        wait_go |=> !wait_over);

    // R7: no further wait is requested once the poll budget is spent.
    a_r7_budget_respected: assert property (@(posedge clk) disable iff (!rst_n)
        !(wait_go && last_try));
endmodule

// File: rtl/phywin_seq.sv
// Module: phywin_seq (top)
// Runs the indirect command protocol of the PHY over the windowed bus. A
// read is: poll, address, start, poll, fetch. A write is: poll, address,
// data, start+write. Assumes one command at a time on the valid/ready port
// and a bus slave that eventually acknowledges every request.
module phywin_seq
    import phywin_pkg::*;
#(
    parameter int DEV_W      = 5,
    parameter int IADDR_W    = 16,
    parameter int DATA_W     = 16,
    parameter int WAIT_TICKS = 1000,
    parameter int MAX_POLLS  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_write,
    input  logic [DEV_W-1:0]   cmd_dev,
    input  logic [IADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0]  cmd_wdata,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output logic               err,
    output logic               bus_req,
    output logic               bus_we,
    output logic [BUS_AW-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ack,
    input  logic [DATA_W-1:0]  bus_rdata
);
    seq_state_e         st;
    step_e              step;
    logic               op_write;
    logic [DEV_W-1:0]   op_dev;
    logic [IADDR_W-1:0] op_addr;
    logic [DATA_W-1:0]  op_wdata;

    logic               acc_start, acc_we, acc_busy, acc_done;
    logic [IADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0]  acc_wdata, acc_rdata;
    logic               polling, busy_seen, wait_go, wait_over, last_try, tries_clr;

    assign cmd_ready = (st == SQ_IDLE);
    assign done      = (st == SQ_FINISH);
    assign acc_start = (st == SQ_ISSUE);
    assign polling   = (step == STP_POLL_PRE) || (step == STP_POLL_POST);
    assign busy_seen = acc_rdata[CTRL_GO_BIT];
    assign wait_go   = (st == SQ_WAIT_ACC) && acc_done && polling && busy_seen && !last_try;
    assign tries_clr = (st == SQ_IDLE) || ((st == SQ_WAIT_ACC) && acc_done && polling && !busy_seen);

    // Register, direction and data of the access for the current step.
    always_comb begin
        acc_we    = 1'b0;
        acc_addr  = IADDR_W'(REG_CTRL);
        acc_wdata = '0;
        case (step)
            STP_ADDR: begin
                acc_we    = 1'b1;
                acc_addr  = IADDR_W'(REG_TADDR);
                acc_wdata = DATA_W'(op_addr);
            end
            STP_DATA: begin
                acc_we    = 1'b1;
                acc_addr  = IADDR_W'(REG_TDATA);
                acc_wdata = op_wdata;
            end
            STP_GO: begin
                acc_we                 = 1'b1;
                acc_wdata[CTRL_GO_BIT] = 1'b1;
                acc_wdata[CTRL_WR_BIT] = op_write;
            end
            STP_FETCH: acc_addr = IADDR_W'(REG_TDATA);
            default: ;
        endcase
    end

    // Command sequencing across steps, poll pacing and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SQ_IDLE;
            step     <= STP_POLL_PRE;
            op_write <= 1'b0;
            op_dev   <= '0;
            op_addr  <= '0;
            op_wdata <= '0;
            rd_data  <= '0;
            err      <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: if (cmd_valid) begin
                    op_write <= cmd_write;
                    op_dev   <= cmd_dev;
                    op_addr  <= cmd_addr;
                    op_wdata <= cmd_wdata;
                    step     <= STP_POLL_PRE;
                    st       <= SQ_ISSUE;
                end
                SQ_ISSUE: st <= SQ_WAIT_ACC;
                SQ_WAIT_ACC: if (acc_done) begin
                    case (step)
                        STP_POLL_PRE, STP_POLL_POST: begin
                            if (!busy_seen) begin
                                step <= (step == STP_POLL_PRE) ? STP_ADDR : STP_FETCH;
                                st   <= SQ_ISSUE;
                            end else if (last_try) begin
                                err <= 1'b1;
                                st  <= SQ_FINISH;
                            end else begin
                                st <= SQ_PACE;
                            end
                        end
                        STP_ADDR: begin
                            step <= op_write ? STP_DATA : STP_GO;
                            st   <= SQ_ISSUE;
                        end
                        STP_DATA: begin
                            step <= STP_GO;
                            st   <= SQ_ISSUE;
                        end
                        STP_GO: begin
                            if (op_write) begin
                                st <= SQ_FINISH;
                            end else begin
                                step <= STP_POLL_POST;
                                st   <= SQ_ISSUE;
                            end
                        end
                        STP_FETCH: begin
                            rd_data <= acc_rdata;
                            st      <= SQ_FINISH;
                        end
                        default: st <= SQ_FINISH;
                    endcase
                end
                SQ_PACE: if (wait_over) st <= SQ_ISSUE;
                SQ_FINISH: begin
                    err     <= 1'b0;
                    rd_data <= '0;
                    st      <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    phywin_bus_master #(
        .DEV_W(DEV_W), .IADDR_W(IADDR_W), .DATA_W(DATA_W)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .acc_start(acc_start), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_dev(op_dev), .acc_wdata(acc_wdata),
        .acc_busy(acc_busy), .acc_done(acc_done), .acc_rdata(acc_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    phywin_poll_pacer #(
        .WAIT_TICKS(WAIT_TICKS), .MAX_POLLS(MAX_POLLS)
    ) u_pacer (
        .clk(clk), .rst_n(rst_n),
        .tries_clr(tries_clr), .wait_go(wait_go),
        .wait_over(wait_over), .last_try(last_try)
    );

    // R9: done lasts one cycle and the block is ready right after it.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));

    // R7: the error flag is only presented together with done.
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R5: a write completes right after its start access, with no final poll.
    a_r5_write_ends_at_go: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_WAIT_ACC && step == STP_GO && op_write && acc_done) |=> done);

    // R8: the captured command does not change while one is outstanding.
    a_r8_command_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && !done) |=> ($stable(op_addr) && $stable(op_write) && $stable(op_dev)));

    // R2: a bus access is only underway while the sequencer waits for it.
    a_r2_access_owned: assert property (@(posedge clk) disable iff (!rst_n)
        acc_busy |-> (st == SQ_WAIT_ACC));
endmodule

// File: tb/tb_phywin_seq.sv
`timescale 1ns/1ps
module tb_phywin_seq;
    localparam int WAIT = 1000;
    localparam int MAXP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [4:0]  cmd_dev = '0;
    logic [15:0] cmd_addr = '0, cmd_wdata = '0;
    logic        cmd_ready, done, err;
    logic [15:0] rd_data;
    logic        bus_req, bus_we;
    logic [11:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;

    phywin_seq #(.WAIT_TICKS(WAIT), .MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_dev(cmd_dev), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .done(done), .rd_data(rd_data), .err(err),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0, n_fails = 0, cyc = 0;
    bit finished = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // ---- PHY model state ----
    logic [11:0] pg = '0;
    bit          pg_fresh = 1'b0;
    int          busy_left = 0, post_busy = 0, ctl_reads = 0, accesses = 0;
    int          last_ctl_cyc = 0, lat = 0;
    bit          last_ctl_busy = 1'b0, pend = 1'b0, pwe = 1'b0;
    logic [11:0] pa = '0;
    logic [4:0]  cur_dev = '0;
    bit          cur_write = 1'b0;
    logic [15:0] tar [32];
    logic [15:0] tdr [32];
    logic [15:0] phy_mem [int];
    logic [15:0] ref_mem [int];

    function automatic int mkey(logic [4:0] d, logic [15:0] a);
        return int'({11'b0, d, a});
    endfunction

    task automatic serve();
        logic [15:0] ia;
        logic [4:0]  dv;
        accesses++;
        if (bus_addr == 12'h800) begin
            check(bus_we, "R1", "page access direction", bus_we, 1);
            check(bus_wdata[11:7] == cur_dev, "R1", "page device field", bus_wdata[11:7], cur_dev);
            pg = bus_wdata[11:0];
            pg_fresh = 1'b1;
        end else begin
            check(pg_fresh, "R1", "window access preceded by page write", pg_fresh, 1);
            check(bus_addr[1:0] == 2'b00 && !bus_addr[11], "R1", "window offset alignment", bus_addr, bus_addr & 12'h7FC);
            pg_fresh = 1'b0;
            ia = {pg[6:0], bus_addr[10:2]};
            dv = pg[11:7];
            check(ia == 16'h80A0 || ia == 16'h80A1 || ia == 16'h80A2, "R3", "internal address", ia, 16'h80A0);
            if (ia == 16'h80A0) begin
                if (bus_we) begin
                    check(bus_wdata == (cur_write ? 16'h3 : 16'h1), cur_write ? "R5" : "R4",
                          "control start value", bus_wdata, cur_write ? 3 : 1);
                    if (bus_wdata[1]) phy_mem[mkey(dv, tar[dv])] = tdr[dv];
                    else tdr[dv] = phy_mem.exists(mkey(dv, tar[dv])) ? phy_mem[mkey(dv, tar[dv])] : 16'h0;
                    busy_left = post_busy;
                end else begin
                    ctl_reads++;
                    if (last_ctl_busy)
                        check(cyc - last_ctl_cyc >= WAIT, "R6", "poll spacing", cyc - last_ctl_cyc, WAIT);
                    last_ctl_cyc = cyc;
                    last_ctl_busy = (busy_left > 0);
                    bus_rdata = (busy_left > 0) ? 16'h1 : 16'h0;
                    if (busy_left > 0) busy_left--;
                end
            end else if (ia == 16'h80A1) begin
                if (bus_we) tar[dv] = bus_wdata; else bus_rdata = tar[dv];
            end else if (ia == 16'h80A2) begin
                if (bus_we) tdr[dv] = bus_wdata; else bus_rdata = tdr[dv];
            end
        end
    endtask

    // PHY bus model: ack after 0..2 idle negedges, ack lasts one cycle.
    initial begin
        for (int i = 0; i < 32; i++) begin tar[i] = '0; tdr[i] = '0; end
        forever begin
            @(negedge clk);
            if (bus_ack) bus_ack = 1'b0;
            else if (rst_n && bus_req) begin
                if (!pend) begin
                    pend = 1'b1; pa = bus_addr; pwe = bus_we; lat = accesses % 3;
                end else begin
                    check(bus_addr == pa && bus_we == pwe, "R2", "request held stable", bus_addr, pa);
                end
                if (lat > 0) lat--;
                else begin
                    serve();
                    bus_ack = 1'b1;
                    pend = 1'b0;
                end
            end
        end
    end

    // ---- scoreboard ----
    typedef struct { logic [15:0] data; bit e; int polls; } exp_t;
    exp_t q[$];

    initial begin
        bit prev_done = 1'b0;
        exp_t x;
        forever begin
            @(negedge clk);
            if (rst_n && prev_done)
                check(!done && cmd_ready, "R9", "done single cycle then ready", done, 0);
            prev_done = done;
            if (rst_n && done) begin
                if (q.size() == 0) check(1'b0, "R9", "unexpected done", 1, 0);
                else begin
                    x = q.pop_front();
                    check(rd_data == x.data, "R4", "returned data", rd_data, x.data);
                    check(err == x.e, "R7", "error flag", err, x.e);
                    check(ctl_reads == x.polls, "R5", "control poll count", ctl_reads, x.polls);
                end
            end
        end
    end

    task automatic do_cmd(bit wr, logic [4:0] dev, logic [15:0] addr, logic [15:0] wd,
                          int pre, int post, bit junk);
        exp_t x;
        if (pre + 1 > MAXP) begin
            x.e = 1; x.polls = MAXP; x.data = 0;
        end else if (wr) begin
            x.e = 0; x.polls = pre + 1; x.data = 0;
            ref_mem[mkey(dev, addr)] = wd;
        end else if (post + 1 > MAXP) begin
            x.e = 1; x.polls = pre + 1 + MAXP; x.data = 0;
        end else begin
            x.e = 0; x.polls = pre + post + 2;
            x.data = ref_mem.exists(mkey(dev, addr)) ? ref_mem[mkey(dev, addr)] : 16'h0;
        end
        while (!cmd_ready) @(negedge clk);
        q.push_back(x);
        busy_left = pre; post_busy = post; ctl_reads = 0; last_ctl_busy = 1'b0;
        cur_dev = dev; cur_write = wr;
        cmd_valid = 1'b1; cmd_write = wr; cmd_dev = dev; cmd_addr = addr; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!cmd_ready, "R8", "ready low while busy", cmd_ready, 0);
        if (junk) begin
            // R8: a command offered while busy must be ignored.
            cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = addr ^ 16'h0100; cmd_wdata = 16'hDEAD;
            repeat (50) @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (q.size() > 0) @(negedge clk);
    endtask

    initial begin
        int acc_snap;
        repeat (5) @(negedge clk);
        // R10: reset values
        check(cmd_ready == 1'b1, "R10", "cmd_ready in reset", cmd_ready, 1);
        check(bus_req == 1'b0, "R10", "bus_req in reset", bus_req, 0);
        check(done == 1'b0, "R10", "done in reset", done, 0);
        check(err == 1'b0, "R10", "err in reset", err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !bus_req && !done && !err, "R10", "state after reset", cmd_ready, 1);

        do_cmd(1, 5'd3,  16'h2005, 16'hBEEF, 0, 0, 0);   // R5 basic write
        do_cmd(0, 5'd3,  16'h2005, 16'h0,    0, 0, 0);   // R4 read back
        do_cmd(1, 5'd1,  16'h2005, 16'h1111, 0, 0, 0);   // R1 other device
        do_cmd(0, 5'd3,  16'h2005, 16'h0,    0, 1, 0);   // R1 device isolation
        do_cmd(1, 5'd17, 16'h0001, 16'h1234, 2, 0, 0);   // R6 paced pre-poll
        do_cmd(0, 5'd17, 16'h0001, 16'h0,    1, 3, 0);   // R6 paced both polls
        do_cmd(0, 5'd3,  16'hFFFF, 16'h0,    0, 0, 0);   // R4 unwritten location
        do_cmd(1, 5'd31, 16'hFFFF, 16'hA5A5, 0, 0, 0);   // R1 top page, top device
        do_cmd(0, 5'd31, 16'hFFFF, 16'h0,    0, 0, 0);
        do_cmd(1, 5'd0,  16'h0000, 16'h0F0F, 0, 0, 0);   // R1 bottom page
        do_cmd(0, 5'd0,  16'h0000, 16'h0,    0, 0, 0);
        do_cmd(1, 5'd5,  16'h1234, 16'h7777, 20, 0, 0); // R7 pre-poll timeout
        do_cmd(0, 5'd5,  16'h1234, 16'h0,    0, 0, 0);   // R7 write not performed
        do_cmd(0, 5'd17, 16'h0001, 16'h0,    0, 20, 0);  // R7 post-poll timeout
        do_cmd(1, 5'd9,  16'h4321, 16'h5A5A, MAXP-1, 0, 0); // R7 last allowed poll
        do_cmd(0, 5'd9,  16'h4321, 16'h0,    0, MAXP-1, 0);
        do_cmd(0, 5'd9,  16'h4321, 16'h0,    2, 0, 1);   // R8 junk while busy
        acc_snap = accesses;
        repeat (40) @(negedge clk);
        check(accesses == acc_snap && cmd_ready, "R8", "no access after ignored command", accesses, acc_snap);
        do_cmd(0, 5'd9,  16'h4221, 16'h0,    0, 0, 0);   // R8 junk write absent

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        wait (cyc >= 180000);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "R9", "watchdog expired", cyc, 180000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule